// File: doc/BRIEF.md
# Three-Lane Video Channel Bonding Deskew

This block lines up three TMDS data lanes that share one pixel clock. Each lane has already found its bit and character boundaries on its own, so the lanes can reach this block with different delays. Each lane presents one 10-bit character per cycle and a flag that says it is aligned. Every lane writes into its own small FIFO. The read side holds each lane back separately until all three lanes show the first control token of a blanking interval at the same time. From then on all three lanes are read together, and a bonded flag marks the output words as valid and in step.

The controller is a three-state machine.
- **WAIT_ALIGN** keeps every FIFO empty. It moves to **HUNT** once all three lanes report alignment.
- **HUNT** drains each lane until that lane has a blanking-start marker at its FIFO head. A lane parks there while the others catch up. It moves to **BONDED** on the cycle all three heads are markers. A FIFO overflow flushes every FIFO and keeps the machine in HUNT.
- **BONDED** reads all lanes every cycle. Any of the following flushes the FIFOs and returns to **HUNT**: a blanking start on only some lanes, an empty FIFO, or an overflow.
- A lane losing alignment returns the machine to **WAIT_ALIGN** from either HUNT or BONDED.

Top module: `bond_deskew`

## Requirements
- R1: During and straight after reset, `bond_ok` is 0 and `bond_word` is all zeros.
- R2: Whenever `bond_ok` is 0, `bond_word` is all zeros.
- R3: Bonding can only happen while all three `lane_aligned` bits are 1. A 0 on any of them clears `bond_ok` in the next cycle and flushes every FIFO. Bonding restarts once all three bits are 1 again.
- R4: A control token is one of 10'b1101010100, 10'b0010101011, 10'b0101010100 and 10'b1010101011. Every other value is a data word. Blanking start on a lane is a control token whose preceding word on that lane was a data word. After a flush the preceding word counts as a control token.
- R5: `bond_ok` rises in the cycle in which all three output lanes carry the blanking-start control token together.
- R6: While `bond_ok` is 1, the three output lanes agree on every cycle: either all carry control tokens, or all carry data words from the same character position.
- R7: With the default depth of 16, lane delays that differ by up to 10 cycles are bonded within two blanking intervals.
- R8: A write into a full FIFO that is not being read flushes every FIFO and restarts the hunt. A skew larger than the FIFO depth therefore never bonds.
- R9: While bonded, a blanking start on only some lanes clears `bond_ok`. The block then bonds again at a later blanking start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| lane_aligned | input | 3 | Per-lane alignment-complete flag, bit i for lane i |
| lane_word | input | 30 | Lane i character at bits [10i+9:10i] |
| bond_word | output | 30 | Deskewed lane i character at bits [10i+9:10i] |
| bond_ok | output | 1 | Lanes bonded and output valid |

## Verification
The assertions check these rules on every cycle:
- a dropped alignment flag clears the bonded flag on the next cycle;
- the outputs are zero while the block is unbonded;
- a rising bonded flag always coincides with control tokens on all three lanes;
- bonded lanes never disagree on whether they carry a token or data.

Some behaviours only the bench scenarios can show:
- skews within the FIFO depth do bond;
- skews beyond it never bond, because the FIFOs keep overflowing;
- a lane delay shifted while bonded is caught at the next blanking start and then re-bonded;
- bonded data words carry matching character positions.

// File: rtl/deskew_pkg.sv
package deskew_pkg;

    localparam int LANE_W = 10;
    localparam int NLANES = 3;

    typedef enum logic [1:0] {
        ST_WAIT_ALIGN = 2'd0,
        ST_HUNT       = 2'd1,
        ST_BONDED     = 2'd2
    } bond_state_t;

    // R4: the four blanking characters
    function automatic logic is_ctl_token(input logic [LANE_W-1:0] w);
        return (w == 10'b1101010100) || (w == 10'b0010101011) ||
               (w == 10'b0101010100) || (w == 10'b1010101011);
    endfunction

endpackage

// File: rtl/lane_fifo.sv
module lane_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_idx, rd_idx;
    logic [AW:0]   count;
    logic          do_wr, do_rd;

    assign empty = (count == '0);
    assign full  = (count == FULL_CNT);
    assign do_rd = rd_en && !empty;
    assign do_wr = wr_en && (!full || do_rd);
    assign head  = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_idx <= '0;
            rd_idx <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_idx <= (wr_idx == LAST) ? '0 : wr_idx + 1'b1;
            if (do_rd) rd_idx <= (rd_idx == LAST) ? '0 : rd_idx + 1'b1;
            unique case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr && !flush && !rst) mem[wr_idx] <= wr_data;
    end

endmodule

// File: rtl/lane_marker.sv
module lane_marker
    import deskew_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              pop,
    input  logic              empty,
    input  logic [LANE_W-1:0] head,
    output logic              at_marker
);
    logic last_ctl;
    logic head_ctl;

    assign head_ctl  = is_ctl_token(head);
    assign at_marker = !empty && head_ctl && !last_ctl;

    always_ff @(posedge clk) begin
        if (rst || flush)
            last_ctl <= 1'b1;
        else if (pop && !empty)
            last_ctl <= head_ctl;
    end

endmodule

// File: rtl/bond_deskew.sv
module bond_deskew
    import deskew_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NLANES-1:0]        lane_aligned,
    input  logic [NLANES*LANE_W-1:0] lane_word,
    output logic [NLANES*LANE_W-1:0] bond_word,
    output logic                     bond_ok
);
    bond_state_t st, nxt;

    logic [LANE_W-1:0] head [NLANES];
    logic [NLANES-1:0] empty, full, mark, pop_req, ovf;
    logic              all_al, all_mark, any_mark, wr, flush, load, fault;

    assign all_al   = &lane_aligned;
    assign all_mark = &mark;
    assign any_mark = |mark;

    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        lane_fifo #(.W(LANE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk     (clk),
            .rst     (rst),
            .flush   (flush),
            .wr_en   (wr),
            .wr_data (lane_word[i*LANE_W +: LANE_W]),
            .rd_en   (pop_req[i]),
            .head    (head[i]),
            .empty   (empty[i]),
            .full    (full[i])
        );
        lane_marker u_mark (
            .clk       (clk),
            .rst       (rst),
            .flush     (flush),
            .pop       (pop_req[i]),
            .empty     (empty[i]),
            .head      (head[i]),
            .at_marker (mark[i])
        );
    end

    always_comb begin
        nxt     = st;
        flush   = 1'b0;
        load    = 1'b0;
        wr      = all_al && (st != ST_WAIT_ALIGN);
        unique case (st)
            ST_HUNT:   pop_req = all_mark ? '1 : (~empty & ~mark);
            ST_BONDED: pop_req = '1;
            default:   pop_req = '0;
        endcase
        ovf   = {NLANES{wr}} & full & ~pop_req;
        fault = (|empty) || (any_mark && !all_mark) || (|ovf);
        unique case (st)
            ST_WAIT_ALIGN: begin
                flush = 1'b1;
                if (all_al) nxt = ST_HUNT;
            end
            ST_HUNT: begin
                if (!all_al) begin
                    flush = 1'b1;
                    nxt   = ST_WAIT_ALIGN;
                end else if (|ovf) begin
                    flush = 1'b1;
                end else if (all_mark) begin
                    load = 1'b1;
                    nxt  = ST_BONDED;
                end
            end
            ST_BONDED: begin
                if (!all_al) begin
                    flush = 1'b1;
                    nxt   = ST_WAIT_ALIGN;
                end else if (fault) begin
                    flush = 1'b1;
                    nxt   = ST_HUNT;
                end else begin
                    load = 1'b1;
                end
            end
            default: begin
                flush = 1'b1;
                nxt   = ST_WAIT_ALIGN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_WAIT_ALIGN;
        else     st <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst || !load) begin
            bond_word <= '0;
            bond_ok   <= 1'b0;
        end else begin
            for (int i = 0; i < NLANES; i++)
                bond_word[i*LANE_W +: LANE_W] <= head[i];
            bond_ok <= 1'b1;
        end
    end

endmodule

// File: rtl/bond_chk.sv
module bond_chk
    import deskew_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic [NLANES-1:0]        lane_aligned,
    input logic [NLANES*LANE_W-1:0] bond_word,
    input logic                     bond_ok
);
    logic c0, c1, c2;
    assign c0 = is_ctl_token(bond_word[0*LANE_W +: LANE_W]);
    assign c1 = is_ctl_token(bond_word[1*LANE_W +: LANE_W]);
    assign c2 = is_ctl_token(bond_word[2*LANE_W +: LANE_W]);

    // R3
    align_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !(&lane_aligned) |=> !bond_ok);

    // R3
    bond_needs_align_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bond_ok) |-> $past(&lane_aligned));

    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !bond_ok |-> (bond_word == '0));

    // R5
    bond_onset_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bond_ok) |-> (c0 && c1 && c2));

    // R6
    lane_kind_chk: assert property (@(posedge clk) disable iff (rst)
        bond_ok |-> ((c0 == c1) && (c1 == c2)));

endmodule

bind bond_deskew bond_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .lane_aligned (lane_aligned),
    .bond_word    (bond_word),
    .bond_ok      (bond_ok)
);

// File: tb/sim_bond_deskew.sv
`timescale 1ns/1ps
module sim_bond_deskew;
    import deskew_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  al;
    logic [29:0] lw;
    logic [29:0] bw;
    logic        bok;

    int checks = 0;
    int errors = 0;
    int t = 0;
    int cyc = 0;
    int dly [3];
    bit chk_en = 1'b1;
    bit prev_ok = 1'b0;
    bit saw_bond = 1'b0;
    bit saw_drop = 1'b0;

    localparam int LINE = 40;
    localparam int ACT  = 30;
    localparam logic [9:0] TOK [4] = '{10'b1101010100, 10'b0010101011,
                                       10'b0101010100, 10'b1010101011};
    // {delay0, delay1, delay2, bond expected}
    localparam logic [15:0] VEC [6] = '{
        {5'd0,  5'd0,  5'd0,  1'b1},
        {5'd0,  5'd3,  5'd7,  1'b1},
        {5'd9,  5'd2,  5'd0,  1'b1},
        {5'd10, 5'd0,  5'd10, 1'b1},
        {5'd0,  5'd20, 5'd0,  1'b0},
        {5'd0,  5'd0,  5'd20, 1'b0}
    };

    always #4 clk = ~clk;

    bond_deskew u0 (
        .clk          (clk),
        .rst          (rst),
        .lane_aligned (al),
        .lane_word    (lw),
        .bond_word    (bw),
        .bond_ok      (bok)
    );

    function automatic logic [9:0] src(input int x, input int ln);
        int p;
        if (x < 0) return TOK[0];
        p = x % LINE;
        if (p < ACT) return {3'b011, 2'(ln), 5'(p)};
        return TOK[(x / LINE) % 4];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic observe();
        logic [9:0] w0, w1, w2;
        bit k0, k1, k2;
        w0 = bw[9:0]; w1 = bw[19:10]; w2 = bw[29:20];
        k0 = is_ctl_token(w0); k1 = is_ctl_token(w1); k2 = is_ctl_token(w2);
        if (bok) saw_bond = 1'b1;
        if (prev_ok && !bok) saw_drop = 1'b1;
        if (chk_en) begin
            if (!bok) chk(bw == '0, "R2 idle output", bw, 0);
            if (bok && !prev_ok)
                chk(k0 && k1 && k2, "R5 onset tokens", {k2, k1, k0}, 3'b111);
            if (bok) begin
                chk(k0 == k1 && k1 == k2, "R6 lane kinds", {k2, k1, k0}, {3{k0}});
                if (!k0 && k0 == k1 && k1 == k2)
                    chk(w0[4:0] == w1[4:0] && w1[4:0] == w2[4:0] &&
                        w0[6:5] == 2'd0 && w1[6:5] == 2'd1 && w2[6:5] == 2'd2,
                        "R6 lane positions", bw, {w0, w0, w0});
            end
        end
        prev_ok = bok;
    endtask

    task automatic step();
        @(negedge clk);
        observe();
        for (int i = 0; i < 3; i++) lw[i*10 +: 10] = src(t - dly[i], i);
        t++;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            $display("FAIL R6 watchdog expired actual=%0d expected=%0d", cyc, 50000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; al = 3'b000; lw = '0;
        for (int i = 0; i < 3; i++) dly[i] = 0;
        repeat (3) step();
        chk(bok == 1'b0 && bw == '0, "R1 in reset", {bok, bw}, 0);
        rst = 1'b0;
        step(); step();
        chk(bok == 1'b0 && bw == '0, "R1 after reset", {bok, bw}, 0);

        // vector table: skew patterns
        for (int s = 0; s < 6; s++) begin
            al = 3'b000;
            dly[0] = int'(VEC[s][15:11]);
            dly[1] = int'(VEC[s][10:6]);
            dly[2] = int'(VEC[s][5:1]);
            step(); step();
            chk(bok == 1'b0, "R3 unaligned clears", bok, 0);
            step();
            al = 3'b111;
            saw_bond = 1'b0;
            repeat (220) step();
            if (VEC[s][0]) begin
                chk(saw_bond == 1'b1, "R7 skew bonded", saw_bond, 1);
                chk(bok == 1'b1, "R7 stays bonded", bok, 1);
            end else begin
                chk(saw_bond == 1'b0, "R8 overflow never bonds", saw_bond, 0);
            end
        end

        // R3: alignment loss while bonded, then recovery
        al = 3'b000; dly[0] = 0; dly[1] = 3; dly[2] = 7;
        repeat (3) step();
        al = 3'b111;
        repeat (150) step();
        chk(bok == 1'b1, "R3 bonded before drop", bok, 1);
        al = 3'b101;
        step(); step();
        chk(bok == 1'b0 && bw == '0, "R3 drop clears", {bok, bw}, 0);
        repeat (3) step();
        al = 3'b111;
        repeat (150) step();
        chk(bok == 1'b1, "R3 rebond after realign", bok, 1);

        // R9: lane delay shift while bonded
        chk_en = 1'b0;
        saw_drop = 1'b0;
        dly[1] = 6;
        for (int n = 0; n < 100; n++) begin
            if (!saw_drop) step();
        end
        chk_en = 1'b1;
        chk(saw_drop == 1'b1, "R9 misaligned onset drops", saw_drop, 1);
        repeat (150) step();
        chk(bok == 1'b1, "R9 rebond", bok, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule